// File: doc/BRIEF.md
# Four-plane framebuffer write datapath

This block is the write path of a byte-addressed display framebuffer that is split across four bit planes. A CPU port carries an address, an 8-bit data byte and separate write and read strobes. Every write stores one byte into the addressed location of all four planes in the same cycle. What each plane receives is computed from a small configuration register file, and four 8-bit read latches keep the plane bytes from the last read.

The configuration holds a write-mode field, a rotate count, a per-plane set/reset enable, a per-plane set/reset colour, a bit mask and a read-plane select. The write mode picks one of four data sources for the planes: the rotated CPU byte (with per-plane constant substitution), the latched bytes copied unchanged, a colour taken from the low nibble of the CPU byte, or the set/reset colour gated by the CPU byte. The bit mask then selects, bit by bit, between the new data and the latched data. A read returns the byte of the selected plane and loads all four latches, which makes read-modify-write pixel updates possible.

Top module: `fb_write_path`

## Requirements
- R1: After reset, every configuration field, all four read latches, every plane byte and `cpu_rdata_o` are zero.
- R2: A configuration write selects its target with `cfg_sel_i`: 0 the whole 8-bit graphics mode register (write mode in bits 1:0), 1 the write-mode field only, 2 the rotate count (bits 2:0), 3 the set/reset enable (bits 3:0, bit k for plane k), 4 the set/reset colour (bits 3:0, bit k for plane k), 5 the bit mask, 6 the read-plane select (bits 1:0). Select 1 replaces bits 1:0 of the graphics mode register and keeps bits 7:2. `cfg_rdata_o` returns the selected register at once, zero-extended; selects 0 and 1 both return the graphics mode register.
- R3: A read (`cpu_re_i` high, `cpu_we_i` low) puts the addressed byte of the plane named by the read-plane select on `cpu_rdata_o` one cycle later and loads all four latches with the four plane bytes at that address.
- R4: A write updates the addressed byte of all four planes at the clock edge; a read issued in the next cycle sees the new values.
- R5: In write mode 0 the CPU byte is rotated right by the rotate count before it is used.
- R6: In write mode 0 a plane whose set/reset enable bit is 1 takes its set/reset colour bit copied to all 8 positions instead of the rotated byte.
- R7: In write mode 0 a bit-mask bit of 0 makes that bit position of every plane keep its latch bit.
- R8: In write mode 1 each plane is written with its own latch byte, whatever the CPU byte is.
- R9: In write mode 2 bit k of the CPU byte, copied to all 8 positions, is the new data for plane k; a bit-mask bit of 1 takes that bit, a 0 keeps the latch bit.
- R10: In write mode 3 the CPU byte ANDed with the bit mask is the per-bit select: a 1 takes the plane's set/reset colour bit, a 0 keeps the latch bit.
- R11: When read and write strobes are both high the write is performed and the read is dropped: latches and `cpu_rdata_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Selected configuration register |
| cpu_addr_i | input | ADDR_W | Framebuffer byte address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_re_i | input | 1 | CPU read strobe |
| cpu_rdata_o | output | 8 | Registered read data |

## Verification
Configuration readback is combinational, so it is compared in the same cycle the select is driven; register writes show up one edge after the strobe. Plane writes land at the strobe edge and are observed through a read issued in the following cycle, whose data is registered and therefore compared one edge after the read strobe, along with the latches it loads. The bench model advances once per edge and compares the read data after every operation, and each plane is checked by stepping the read-plane select through all four values.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_PLANES = 4;
  localparam int unsigned ROT_W    = $clog2(DATA_W);
  localparam int unsigned PSEL_W   = $clog2(N_PLANES);

  typedef enum logic [1:0] {
    WM_ROT_SR   = 2'd0,
    WM_LATCH    = 2'd1,
    WM_COLOUR   = 2'd2,
    WM_SR_GATED = 2'd3
  } wmode_e;

  typedef enum logic [2:0] {
    SEL_GMODE    = 3'd0,
    SEL_WMODE    = 3'd1,
    SEL_ROT      = 3'd2,
    SEL_SR_EN    = 3'd3,
    SEL_SR_VAL   = 3'd4,
    SEL_MASK     = 3'd5,
    SEL_RD_PLANE = 3'd6
  } cfg_sel_e;

  typedef struct packed {
    logic [DATA_W-1:0]   gmode;
    logic [ROT_W-1:0]    rot;
    logic [N_PLANES-1:0] sr_en;
    logic [N_PLANES-1:0] sr_val;
    logic [DATA_W-1:0]   mask;
    logic [PSEL_W-1:0]   rd_plane;
  } cfg_t;

  typedef logic [N_PLANES-1:0][DATA_W-1:0] plane_bytes_t;
endpackage

// File: rtl/fb_cfg_regs.sv
module fb_cfg_regs
  import fb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_GMODE:    cfg_q.gmode       <= wdata_i;
        SEL_WMODE:    cfg_q.gmode[1:0]  <= wdata_i[1:0];
        SEL_ROT:      cfg_q.rot         <= wdata_i[ROT_W-1:0];
        SEL_SR_EN:    cfg_q.sr_en       <= wdata_i[N_PLANES-1:0];
        SEL_SR_VAL:   cfg_q.sr_val      <= wdata_i[N_PLANES-1:0];
        SEL_MASK:     cfg_q.mask        <= wdata_i;
        SEL_RD_PLANE: cfg_q.rd_plane    <= wdata_i[PSEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (cfg_sel_e'(sel_i))
      SEL_GMODE, SEL_WMODE: rdata_o = cfg_q.gmode;
      SEL_ROT:      rdata_o[ROT_W-1:0]    = cfg_q.rot;
      SEL_SR_EN:    rdata_o[N_PLANES-1:0] = cfg_q.sr_en;
      SEL_SR_VAL:   rdata_o[N_PLANES-1:0] = cfg_q.sr_val;
      SEL_MASK:     rdata_o               = cfg_q.mask;
      SEL_RD_PLANE: rdata_o[PSEL_W-1:0]   = cfg_q.rd_plane;
      default: ;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/fb_plane_mem.sv
module fb_plane_mem #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/fb_write_unit.sv
module fb_write_unit
  import fb_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  plane_bytes_t      latch_i,
  output plane_bytes_t      wdata_o
);
  wmode_e              mode;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   rotated;
  logic [DATA_W-1:0]   gate3;

  assign mode    = wmode_e'(cfg_i.gmode[1:0]);
  assign dbl     = {cpu_wdata_i, cpu_wdata_i} >> cfg_i.rot;
  assign rotated = dbl[DATA_W-1:0];
  assign gate3   = cpu_wdata_i & cfg_i.mask;

  for (genvar k = 0; k < N_PLANES; k++) begin : g_plane
    logic [DATA_W-1:0] srbyte, fresh, sel;
    assign srbyte = {DATA_W{cfg_i.sr_val[k]}};

    always_comb begin
      unique case (mode)
        WM_ROT_SR:   begin fresh = cfg_i.sr_en[k] ? srbyte : rotated; sel = cfg_i.mask; end
        WM_LATCH:    begin fresh = latch_i[k];                       sel = '0;         end
        WM_COLOUR:   begin fresh = {DATA_W{cpu_wdata_i[k]}};         sel = cfg_i.mask; end
        WM_SR_GATED: begin fresh = srbyte;                           sel = gate3;      end
        default:     begin fresh = latch_i[k];                       sel = '0;         end
      endcase
      wdata_o[k] = (fresh & sel) | (latch_i[k] & ~sel);
    end
  end
endmodule

// File: rtl/fb_write_path.sv
module fb_write_path
  import fb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  output logic [7:0]        cpu_rdata_o
);
  cfg_t         cfg;
  plane_bytes_t latch_q, plane_wd, plane_rd;
  logic [DATA_W-1:0] rd_sel_word;
  logic         rd_take;

  fb_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  fb_write_unit u_wu (
    .cfg_i       (cfg),
    .cpu_wdata_i (cpu_wdata_i),
    .latch_i     (latch_q),
    .wdata_o     (plane_wd)
  );

  for (genvar k = 0; k < N_PLANES; k++) begin : g_mem
    fb_plane_mem #(.ADDR_W(ADDR_W), .DW(DATA_W)) u_mem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cpu_we_i),
      .addr_i  (cpu_addr_i),
      .wdata_i (plane_wd[k]),
      .rdata_o (plane_rd[k])
    );
  end

  assign rd_take     = cpu_re_i & ~cpu_we_i;  // write wins
  assign rd_sel_word = plane_rd[cfg.rd_plane];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q     <= '0;
      cpu_rdata_o <= '0;
    end else if (rd_take) begin
      latch_q     <= plane_rd;
      cpu_rdata_o <= rd_sel_word;
    end
  end
endmodule

// File: rtl/fb_write_path_chk.sv
module fb_write_path_chk
  import fb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [2:0]        cfg_sel_i,
  input logic              cpu_we_i,
  input logic              cpu_re_i,
  input logic [7:0]        cpu_rdata_o,
  input cfg_t              cfg,
  input plane_bytes_t      latch_q,
  input plane_bytes_t      plane_wd,
  input logic [DATA_W-1:0] rd_sel_word
);
  p_field_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i == 3'd1 |=> cfg.gmode[7:2] == $past(cfg.gmode[7:2]));

  p_read_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_re_i && !cpu_we_i |=> cpu_rdata_o == $past(rd_sel_word));

  p_mask_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && cfg.gmode[1:0] == 2'd0 |-> ((plane_wd ^ latch_q) & {N_PLANES{~cfg.mask}}) == '0);

  p_latch_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && cfg.gmode[1:0] == 2'd1 |-> plane_wd == latch_q);

  p_colour_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && cfg.gmode[1:0] == 2'd2 |-> ((plane_wd ^ latch_q) & {N_PLANES{~cfg.mask}}) == '0);

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |=> latch_q == $past(latch_q) && cpu_rdata_o == $past(cpu_rdata_o));
endmodule

bind fb_write_path fb_write_path_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_sel_i   (cfg_sel_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_re_i    (cpu_re_i),
  .cpu_rdata_o (cpu_rdata_o),
  .cfg         (cfg),
  .latch_q     (latch_q),
  .plane_wd    (plane_wd),
  .rd_sel_word (rd_sel_word)
);

// File: tb/fb_write_path_tb.sv
module fb_write_path_tb;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cpu_we = 0, cpu_re = 0;
  logic [2:0] cfg_sel = 0;
  logic [7:0] cfg_wd = 0, cpu_wd = 0, cfg_rd, cpu_rd;
  logic [AW-1:0] addr = 0;

  always #4 clk = ~clk;

  fb_write_path #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd),
    .cpu_addr_i(addr), .cpu_wdata_i(cpu_wd), .cpu_we_i(cpu_we), .cpu_re_i(cpu_re),
    .cpu_rdata_o(cpu_rd)
  );

  // reference state
  int m_mem [4][16];
  int m_lat [4];
  int m_gmode, m_rot, m_en, m_val, m_mask, m_rdp, m_rdata;
  int total = 0, bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int bit_of(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  function automatic int model_plane(input int k, input int d);
    int res = 0;
    int rot_d = 0;
    for (int b = 0; b < 8; b++) rot_d |= bit_of(d, (b + m_rot) % 8) << b;
    for (int b = 0; b < 8; b++) begin
      int nb;
      int lb = bit_of(m_lat[k], b);
      case (m_gmode & 3)
        0: begin
          int src = (bit_of(m_en, k) != 0) ? bit_of(m_val, k) : bit_of(rot_d, b);
          nb = bit_of(m_mask, b) ? src : lb;
        end
        1: nb = lb;
        2: nb = bit_of(m_mask, b) ? bit_of(d, k) : lb;
        default: nb = (bit_of(m_mask, b) & bit_of(d, b)) ? bit_of(m_val, k) : lb;
      endcase
      res |= nb << b;
    end
    return res;
  endfunction

  // one bus cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cpu_op(input bit we, input bit re, input int a, input int d, input string tag);
    addr = a[AW-1:0]; cpu_wd = d[7:0]; cpu_we = we; cpu_re = re;
    @(posedge clk);
    if (we) begin
      int nw [4];
      for (int k = 0; k < 4; k++) nw[k] = model_plane(k, d);
      for (int k = 0; k < 4; k++) m_mem[k][a] = nw[k];
    end else if (re) begin
      for (int k = 0; k < 4; k++) m_lat[k] = m_mem[k][a];
      m_rdata = m_mem[m_rdp][a];
    end
    @(negedge clk);
    cpu_we = 0; cpu_re = 0;
    chk(tag, cpu_rd, m_rdata);
  endtask

  task automatic cfg_write(input int sel, input int v);
    cfg_sel = sel[2:0]; cfg_wd = v[7:0]; cfg_we = 1;
    @(posedge clk);
    case (sel)
      0: m_gmode = v & 8'hFF;
      1: m_gmode = (m_gmode & 8'hFC) | (v & 3);
      2: m_rot   = v & 7;
      3: m_en    = v & 15;
      4: m_val   = v & 15;
      5: m_mask  = v & 8'hFF;
      6: m_rdp   = v & 3;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_check(input int sel, input int exp, input string tag);
    cfg_sel = sel[2:0];
    #1;
    chk(tag, cfg_rd, exp);
  endtask

  // read addressed byte of every plane via the read-plane select
  task automatic planes(input int a, input string tag);
    for (int k = 0; k < 4; k++) begin
      cfg_write(6, k);
      cpu_op(0, 1, a, 0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_lat[k] = 0;
      for (int a = 0; a < 16; a++) m_mem[k][a] = 0;
    end
    m_gmode = 0; m_rot = 0; m_en = 0; m_val = 0; m_mask = 0; m_rdp = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", cpu_rd, 0);
    for (int s = 0; s < 7; s++) cfg_check(s, 0, "R1 cfg");
    planes(3, "R1 planes");
    // mode 1 write copies latches: all zero after reset
    cfg_write(1, 1);
    cpu_op(1, 0, 12, 8'hEE, "R1 latch");
    planes(12, "R1 latch");

    // R2 register map and write-mode field
    cfg_write(0, 8'hA4);  cfg_check(0, 8'hA4, "R2 gmode");
    cfg_write(1, 8'hFF);  cfg_check(1, 8'hA7, "R2 field keep");
    cfg_write(1, 8'h00);  cfg_check(0, 8'hA4, "R2 field keep");
    cfg_write(2, 8'hFB);  cfg_check(2, 3, "R2 rot");
    cfg_write(5, 8'hFF);  cfg_check(5, 8'hFF, "R2 mask");
    cfg_write(3, 8'hF0);  cfg_check(3, 0, "R2 sr_en");
    cfg_write(4, 8'h39);  cfg_check(4, 9, "R2 sr_val");
    cfg_check(7, 0, "R2 unused");

    // R5 rotate sweep, R4 all planes updated
    cpu_op(1, 0, 1, 8'h96, "R4 write");
    planes(1, "R5 rot3");
    for (int r = 0; r < 8; r++) begin
      cfg_write(2, r);
      cpu_op(1, 0, 10, 8'h81 ^ (r << 2), "R5 sweep");
      cpu_op(0, 1, 10, 0, "R5 sweep");
    end

    // R6 set/reset substitution
    cfg_write(2, 0); cfg_write(3, 4'b0101); cfg_write(4, 4'b0011);
    cpu_op(1, 0, 2, 8'h5A, "R6 write");
    planes(2, "R6 sr");

    // R7 bit mask in mode 0
    cfg_write(3, 0); cfg_write(5, 8'h0F); cfg_write(6, 1);
    cpu_op(0, 1, 1, 0, "R7 load");
    cpu_op(1, 0, 4, 8'h3C, "R7 write");
    planes(4, "R7 mask");

    // R8 latch copy
    cfg_write(1, 1); cfg_write(6, 2);
    cpu_op(0, 1, 2, 0, "R8 load");
    cpu_op(1, 0, 5, 8'h77, "R8 write");
    planes(5, "R8 copy");

    // R9 colour mode
    cfg_write(1, 2); cfg_write(5, 8'hF0);
    cpu_op(0, 1, 1, 0, "R9 load");
    cpu_op(1, 0, 6, 8'hF9, "R9 write");
    planes(6, "R9 colour");
    cfg_write(5, 8'h81);
    cpu_op(0, 1, 2, 0, "R9 load");
    cpu_op(1, 0, 11, 8'h06, "R9 write");
    planes(11, "R9 colour");

    // R10 gated set/reset
    cfg_write(1, 3); cfg_write(4, 4'b0110); cfg_write(5, 8'h3C);
    cpu_op(0, 1, 2, 0, "R10 load");
    cpu_op(1, 0, 7, 8'hE7, "R10 write");
    planes(7, "R10 gated");

    // R11 simultaneous read and write
    cfg_write(6, 0);
    cpu_op(0, 1, 1, 0, "R11 load");
    cfg_write(1, 0); cfg_write(5, 8'hFF); cfg_write(3, 0); cfg_write(2, 0);
    cpu_op(1, 1, 2, 8'h11, "R11 rdata hold");
    cfg_write(1, 1);
    cpu_op(1, 0, 9, 8'h00, "R11 latch hold");
    planes(9, "R11 latch hold");
    planes(2, "R11 write done");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule